// File: doc/BRIEF.md
# Output Driver Fault Protection Controller

This block applies the protection policy to an eight-channel high-side switch array. It sits between the latched command byte and the gate enables. It takes three inputs about the outputs: the sensed logic level of each output pin, a chip-wide over-temperature flag, and a well-formed-frame pulse from the serial front end. From these it decides which enables may actually be driven. It also produces the diagnostic byte that the serial front end shifts out.

Each channel watches for an output that is enabled but reads low. If that condition lasts a parameterised number of consecutive clock cycles, the channel is latched off as shorted to ground. The latch clears when the command for that channel goes off, or when a well-formed frame commands it on again. A rise of the over-temperature flag sets a global thermal latch. While that latch is set, every enable is off and each diagnostic bit is the inverse of its command. The thermal latch is released only by a well-formed frame that arrives after the flag has dropped. A low powerdown input or a low supply-good input turns every enable off. Powerdown also holds the debounce counters at zero.

Top module: `drv_protect_ctrl`

## Requirements
- R1: During and directly after synchronous reset, `en_o` and `diag_o` are all zero and no fault is latched.
- R2: With no fault latched, `pd_n_i` high and `supply_ok_i` high, `en_o` equals `cmd_i` one clock later. An enable bit is never 1 unless the matching command bit was 1 in the previous cycle.
- R3: While the thermal latch is clear, `diag_o[i]` equals `sense_i[i]` one clock later, with 1 meaning the pin reads high and 0 meaning it reads low.
- R4: When a channel's `en_o` bit is 1 and its `sense_i` bit is 0 for DEB_CYC consecutive clock edges, that channel's short latch sets on the last of those edges. Its `en_o` bit goes to 0 on the following edge, which is DEB_CYC+1 edges after the sense bit first fell. Other channels are unaffected.
- R5: A low sense period shorter than DEB_CYC edges has no effect, and the debounce count restarts from zero whenever the condition goes away.
- R6: A latched short clears on any edge where that channel's `cmd_i` bit is 0. It also clears on an edge where `frame_ok_i` is 1 and the channel's `cmd_i` bit is 1, and `en_o` then follows the command again one edge later.
- R7: `ot_i` high sets the thermal latch on the next edge. From the edge after that, `en_o` is all zero and `diag_o` equals the bitwise inverse of `cmd_i`, so on-commanded channels read 0 and off-commanded channels read 1.
- R8: The thermal latch clears only on an edge where `frame_ok_i` is 1 and `ot_i` is 0. A frame pulse while `ot_i` is high, or a cooled flag with no frame, leaves it set.
- R9: While `pd_n_i` is low, `en_o` is all zero from the next edge and the debounce counters are held at zero. After release, a short needs a full DEB_CYC edges of debounce again.
- R10: While `supply_ok_i` is low, `en_o` is all zero from the next edge. After supply returns, the enables follow the command again.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | N_CH | Commanded on/off state per channel, 1 = on |
| frame_ok_i | input | 1 | One-cycle pulse marking a well-formed serial frame |
| sense_i | input | N_CH | Sensed output pin level per channel, 1 = high |
| ot_i | input | 1 | Over-temperature flag, 1 = too hot |
| pd_n_i | input | 1 | Powerdown, active low |
| supply_ok_i | input | 1 | Both supplies present, 1 = good |
| en_o | output | N_CH | Registered gate enable per channel |
| diag_o | output | N_CH | Registered diagnostic bit per channel |

## Verification
The bench times the short debounce to the exact edge. A counter that is off by one would drop the enable an edge early or late. A low glitch of DEB_CYC-1 edges, a one-edge recovery and then a second such glitch checks that the counter restarts; a counter that only pauses would latch a healthy channel off. The thermal latch is tested three ways: a frame pulse while still hot, a cooled flag with no frame, and finally a frame after cooling. A latch keyed on the flag alone would release early, and one that ignored the flag would release while hot. Powerdown is pulsed in the middle of a partial debounce; a design that kept the count across powerdown would trip short of a full window afterwards.

// File: rtl/drv_protect_pkg.sv
package drv_protect_pkg;
  // 5.4 ms at a 50 MHz system clock
  parameter int unsigned DEFAULT_DEB_CYC = 270000;
  parameter int unsigned DEFAULT_N_CH    = 8;

  // fault value of a diagnostic byte: inverse of the command
  function automatic logic [DEFAULT_N_CH-1:0] fault_diag(input logic [DEFAULT_N_CH-1:0] cmd);
    return ~cmd;
  endfunction
endpackage

// File: rtl/drv_chan_guard.sv
module drv_chan_guard #(
  parameter int unsigned DEB_CYC = drv_protect_pkg::DEFAULT_DEB_CYC
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic en_i,
  input  logic sense_i,
  input  logic cmd_i,
  input  logic retry_i,
  output logic short_o
);
  localparam int unsigned CNT_W = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             short_q;
  logic             cond;
  logic             expire;

  assign cond   = en_i & ~sense_i & ~short_q & ~hold_i;
  assign expire = cond && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else begin
      if (!cond || expire) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
      if (!cmd_i || retry_i) short_q <= 1'b0;
      else if (expire)       short_q <= 1'b1;
    end
  end

  assign short_o = short_q;

  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hold_i) |-> (cnt_q == '0));
  // R6
  short_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cmd_i) |-> !short_q);
  // R4
  short_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(short_q) |-> ($past(cnt_q) == LAST && $past(en_i) && !$past(sense_i)));
endmodule

// File: rtl/drv_thermal_latch.sv
module drv_thermal_latch (
  input  logic clk,
  input  logic rst,
  input  logic ot_i,
  input  logic frame_ok_i,
  output logic tsd_o
);
  logic tsd_q;

  always_ff @(posedge clk) begin
    if (rst)             tsd_q <= 1'b0;
    else if (ot_i)       tsd_q <= 1'b1;
    else if (frame_ok_i) tsd_q <= 1'b0;
  end

  assign tsd_o = tsd_q;

  // R7
  ot_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ot_i) |-> tsd_q);
  // R8
  tsd_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tsd_q) |-> ($past(frame_ok_i) && !$past(ot_i)));
endmodule

// File: rtl/drv_protect_ctrl.sv
module drv_protect_ctrl #(
  parameter int unsigned N_CH    = drv_protect_pkg::DEFAULT_N_CH,
  parameter int unsigned DEB_CYC = drv_protect_pkg::DEFAULT_DEB_CYC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] cmd_i,
  input  logic            frame_ok_i,
  input  logic [N_CH-1:0] sense_i,
  input  logic            ot_i,
  input  logic            pd_n_i,
  input  logic            supply_ok_i,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] diag_o
);
  logic [N_CH-1:0] en_q;
  logic [N_CH-1:0] diag_q;
  logic [N_CH-1:0] short_v;
  logic            tsd;
  logic            allow;

  drv_thermal_latch u_tsd (
    .clk        (clk),
    .rst        (rst),
    .ot_i       (ot_i),
    .frame_ok_i (frame_ok_i),
    .tsd_o      (tsd)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    drv_chan_guard #(.DEB_CYC(DEB_CYC)) u_guard (
      .clk     (clk),
      .rst     (rst),
      .hold_i  (~pd_n_i),
      .en_i    (en_q[g]),
      .sense_i (sense_i[g]),
      .cmd_i   (cmd_i[g]),
      .retry_i (frame_ok_i),
      .short_o (short_v[g])
    );
  end

  assign allow = ~tsd & pd_n_i & supply_ok_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      diag_q <= '0;
    end else begin
      en_q   <= allow ? (cmd_i & ~short_v) : '0;
      diag_q <= tsd ? ~cmd_i : sense_i;
    end
  end

  assign en_o   = en_q;
  assign diag_o = diag_q;

  // R2
  en_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((en_q & ~$past(cmd_i)) == '0));
  // R9
  pd_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pd_n_i) |-> (en_q == '0));
  // R10
  supply_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok_i) |-> (en_q == '0));
  // R7
  tsd_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tsd) |-> (en_q == '0 && diag_q == ~$past(cmd_i)));
endmodule

// File: tb/test_drv_protect_ctrl.sv
module test_drv_protect_ctrl;
  localparam int N   = 8;
  localparam int DEB = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] cmd, sense, en, diag;
  logic         frame_ok, ot, pd_n, sup;
  int           n_chk = 0;
  int           n_bad = 0;

  always #10 clk = ~clk;

  drv_protect_ctrl #(.N_CH(N), .DEB_CYC(DEB)) i_drv_protect_ctrl (
    .clk(clk), .rst(rst), .cmd_i(cmd), .frame_ok_i(frame_ok), .sense_i(sense),
    .ot_i(ot), .pd_n_i(pd_n), .supply_ok_i(sup), .en_o(en), .diag_o(diag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; cmd = '0; sense = '0; frame_ok = 1'b0; ot = 1'b0; pd_n = 1'b1; sup = 1'b1;
    tick(3);
    check("R1 en in reset", en, '0);
    check("R1 diag in reset", diag, '0);
    rst = 1'b0;
    tick(1);
    check("R1 en after reset", en, '0);
  endtask

  task automatic t_follow();
    cmd = 8'hA5; sense = 8'h3C;
    tick(1);
    check("R2 en follows cmd", en, 8'hA5);
    check("R3 diag follows sense", diag, 8'h3C);
    cmd = 8'h5A; sense = 8'hC3;
    tick(1);
    check("R2 en follows cmd 2", en, 8'h5A);
    check("R3 diag follows sense 2", diag, 8'hC3);
    cmd = 8'hFF; sense = 8'hFF;
    tick(2);
  endtask

  task automatic t_short();
    sense[0] = 1'b0;
    tick(DEB);
    check("R4 en still on at window end", en, 8'hFF);
    tick(1);
    check("R4 shorted channel off", en, 8'hFE);
    check("R3 diag reads low pin", diag, 8'hFE);
    cmd = 8'hFE;
    tick(2);
    cmd = 8'hFF; sense = 8'hFF;
    tick(2);
    check("R6 cleared by off command", en, 8'hFF);
    sense[0] = 1'b0;
    tick(DEB + 1);
    check("R4 relatch", en, 8'hFE);
    tick(3);
    check("R6 latch holds without frame", en, 8'hFE);
    frame_ok = 1'b1;
    tick(1);
    frame_ok = 1'b0;
    tick(1);
    check("R6 cleared by frame retry", en, 8'hFF);
    sense = 8'hFF;
    tick(2);
  endtask

  task automatic t_glitch();
    sense[2] = 1'b0; tick(DEB - 1);
    sense[2] = 1'b1; tick(1);
    sense[2] = 1'b0; tick(DEB - 1);
    sense[2] = 1'b1; tick(3);
    check("R5 glitches do not latch", en, 8'hFF);
  endtask

  task automatic t_indep();
    sense[3] = 1'b0;
    tick(DEB + 2);
    check("R4 only channel 3 off", en, 8'hF7);
    cmd = 8'h77; sense = 8'hFF;
    tick(2);
    cmd = 8'hFF;
    tick(2);
    check("R6 channel 3 restored", en, 8'hFF);
  endtask

  task automatic t_thermal();
    cmd = 8'h0F; sense = 8'h0F;
    tick(2);
    ot = 1'b1;
    tick(2);
    check("R7 enables off", en, 8'h00);
    check("R7 diag fault values", diag, 8'hF0);
    frame_ok = 1'b1; tick(1); frame_ok = 1'b0;
    tick(2);
    check("R8 frame while hot ignored", en, 8'h00);
    ot = 1'b0;
    tick(4);
    check("R8 cooled without frame holds", en, 8'h00);
    check("R8 diag still faulted", diag, 8'hF0);
    frame_ok = 1'b1; tick(1); frame_ok = 1'b0;
    tick(1);
    check("R8 released en", en, 8'h0F);
    check("R8 released diag", diag, 8'h0F);
    cmd = 8'hFF; sense = 8'hFF;
    tick(2);
  endtask

  task automatic t_power();
    pd_n = 1'b0;
    tick(1);
    check("R9 powerdown off", en, 8'h00);
    pd_n = 1'b1;
    tick(1);
    check("R9 powerdown release", en, 8'hFF);
    sense[1] = 1'b0;
    tick(DEB - 2);
    pd_n = 1'b0; tick(1); pd_n = 1'b1;
    tick(DEB);
    check("R9 full window after powerdown", en, 8'hFF);
    tick(2);
    check("R9 latches after full window", en, 8'hFD);
    cmd = 8'hFD; sense = 8'hFF; tick(2); cmd = 8'hFF; tick(2);
    sup = 1'b0;
    tick(1);
    check("R10 supply loss off", en, 8'h00);
    tick(3);
    check("R10 stays off", en, 8'h00);
    sup = 1'b1;
    tick(1);
    check("R10 supply return", en, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_follow();
    t_short();
    t_glitch();
    t_indep();
    t_thermal();
    t_power();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule